// File: doc/BRIEF.md
# Configurable Product-Term AND Plane

This block is the AND plane of one logic block in a small programmable-logic fabric. It receives a bus of 36 routed signals and turns each one into two literal lines, one true and one inverted. From those 72 lines it builds 83 product terms. Each term is the AND of whichever lines its configuration mask connects, in the manner of a wired-AND. The first 80 terms are logic terms, grouped into 16 clusters of five that feed the per-macrocell OR stage further downstream. The last three terms are dedicated control terms. They serve as a shared clock, a shared initialization and a shared output enable, and the first two of these can be inverted by a configuration bit.

Configuration is a static bit-vector. It is shifted in serially, one bit per clock, while a load-enable input is high. While that input is high, every output is forced low, so the downstream logic never sees a half-written array. When loading is complete, the path from the input bus to the terms is purely combinational. No register lies between the inputs and the product-term outputs.

Top module: `pt_and_plane`

## Requirements
- R1: Literal line 2*i carries input i, and line 2*i+1 carries the complement of input i. A product term is the AND of every line whose mask bit is 1 (1 = connected).
- R2: Output `logic_pt[t]` carries product term t for t in 0..79. Cluster c occupies `logic_pt[5*c+4 : 5*c]`.
- R3: A product term whose mask has no connected line evaluates to 1.
- R4: A product term that connects both line 2*i and line 2*i+1 of the same input evaluates to 0 for every input value.
- R5: `shr_clk` is term 80 XOR the clock-invert bit. `shr_init` is term 81 XOR the init-invert bit. `shr_oe` is term 82, with no inversion.
- R6: While `cfg_ld` is high, each rising clock edge shifts `cfg_sdi` into a 5978-bit configuration vector at bit 0, and every other bit moves up one place. In that vector, bit 0 is the clock-invert bit and bit 1 is the init-invert bit. Mask bit l of term t sits at bit 2+72*t+l. The bits are therefore sent from bit 5977 (term 82, line 71) down to bit 0.
- R7: While `cfg_ld` is high, all 83 term outputs are 0.
- R8: While `cfg_ld` is low, the configuration does not change, whatever `cfg_sdi` and the clock do. The outputs follow `lit_in` combinationally, with no clock edge needed.
- R9: Reset clears the whole configuration vector. After reset, with `cfg_ld` low, every output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Active-low asynchronous reset of the configuration |
| cfg_ld | input | 1 | Load enable for serial configuration |
| cfg_sdi | input | 1 | Serial configuration data |
| lit_in | input | 36 | Routed input signals |
| logic_pt | output | 80 | Logic product terms, 16 clusters of five |
| shr_clk | output | 1 | Shared clock term, optionally inverted |
| shr_init | output | 1 | Shared initialization term, optionally inverted |
| shr_oe | output | 1 | Shared output-enable term |

## Verification
A wrong configuration bit cannot hide in this block. As soon as loading ends, it changes the value of one term for some input pattern, with no cycle of delay. The bench therefore compares all 83 terms against its own model on every input vector it applies. A misplaced bit in the shift order moves a literal to another line or another term, and shows up as a term that disagrees with the model. A missing or wrong inversion shows up on the shared clock or initialization output. A leak of a half-loaded array is caught by sampling the outputs in the middle of a load. A config register that moves while loading is idle is caught by clocking with the load enable low and then checking the outputs again.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  // Number of inversion bits that precede the term masks in the config vector.
  localparam int unsigned INV_BITS = 2;
  // Positions of the inversion bits inside the config vector.
  localparam int unsigned INV_CLK_BIT  = 0;
  localparam int unsigned INV_INIT_BIT = 1;

  // Dedicated control terms, in order after the logic terms.
  typedef enum int unsigned {
    SH_CLK  = 0,
    SH_INIT = 1,
    SH_OE   = 2
  } shared_term_e;
  localparam int unsigned N_SHARED = 3;
endpackage

// File: rtl/pt_cfg_shift.sv
`timescale 1ns/1ps
module pt_cfg_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         sdi,
  output logic [W-1:0] cfg_q
);
  // Serial entry at bit 0; the first bit sent ends up at bit W-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ld) begin
      cfg_q <= {cfg_q[W-2:0], sdi};
    end
  end
endmodule

// File: rtl/pt_literal_gen.sv
`timescale 1ns/1ps
module pt_literal_gen #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned N_LINE = 2 * N_IN
) (
  input  logic [N_IN-1:0]   sig_in,
  output logic [N_LINE-1:0] lines
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lines[2*i]   = sig_in[i];
    assign lines[2*i+1] = ~sig_in[i];
  end
endmodule

// File: rtl/pt_term.sv
`timescale 1ns/1ps
module pt_term #(
  parameter int unsigned N_LINE = 8
) (
  input  logic [N_LINE-1:0] mask,
  input  logic [N_LINE-1:0] lines,
  output logic              hot
);
  // Wired-AND: an unconnected line pulls nothing low.
  function automatic logic wired_and(input logic [N_LINE-1:0] m,
                                     input logic [N_LINE-1:0] l);
    return &(l | ~m);
  endfunction

  assign hot = wired_and(mask, lines);
endmodule

// File: rtl/pt_and_plane.sv
`timescale 1ns/1ps
module pt_and_plane #(
  parameter int unsigned N_IN    = 36,
  parameter int unsigned N_CL    = 16,
  parameter int unsigned CL_SIZE = 5,
  localparam int unsigned N_LINE  = 2 * N_IN,
  localparam int unsigned N_LOGIC = N_CL * CL_SIZE,
  localparam int unsigned N_PT    = N_LOGIC + pt_pkg::N_SHARED,
  localparam int unsigned CFG_W   = pt_pkg::INV_BITS + N_PT * N_LINE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_ld,
  input  logic               cfg_sdi,
  input  logic [N_IN-1:0]    lit_in,
  output logic [N_LOGIC-1:0] logic_pt,
  output logic               shr_clk,
  output logic               shr_init,
  output logic               shr_oe
);
  import pt_pkg::*;

  logic [CFG_W-1:0]  cfg_q;
  logic [N_LINE-1:0] lines;
  logic [N_PT-1:0]   pt_raw;     // ungated term values, named for the checker
  logic              inv_clk;
  logic              inv_init;

  pt_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (cfg_ld),
    .sdi   (cfg_sdi),
    .cfg_q (cfg_q)
  );

  pt_literal_gen #(.N_IN(N_IN)) u_lit (
    .sig_in (lit_in),
    .lines  (lines)
  );

  // Logic terms, laid out cluster by cluster.
  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    for (genvar k = 0; k < CL_SIZE; k++) begin : g_pt
      localparam int unsigned T = c * CL_SIZE + k;
      pt_term #(.N_LINE(N_LINE)) u_term (
        .mask  (cfg_q[INV_BITS + T*N_LINE +: N_LINE]),
        .lines (lines),
        .hot   (pt_raw[T])
      );
    end
  end

  // Dedicated control terms follow the logic terms.
  for (genvar s = 0; s < N_SHARED; s++) begin : g_sh
    localparam int unsigned T = N_LOGIC + s;
    pt_term #(.N_LINE(N_LINE)) u_term (
      .mask  (cfg_q[INV_BITS + T*N_LINE +: N_LINE]),
      .lines (lines),
      .hot   (pt_raw[T])
    );
  end

  assign inv_clk  = cfg_q[INV_CLK_BIT];
  assign inv_init = cfg_q[INV_INIT_BIT];

  // Outputs are forced low while the array is being rewritten.
  always_comb begin
    if (cfg_ld) begin
      logic_pt = '0;
      shr_clk  = 1'b0;
      shr_init = 1'b0;
      shr_oe   = 1'b0;
    end else begin
      logic_pt = pt_raw[N_LOGIC-1:0];
      shr_clk  = pt_raw[N_LOGIC + SH_CLK]  ^ inv_clk;
      shr_init = pt_raw[N_LOGIC + SH_INIT] ^ inv_init;
      shr_oe   = pt_raw[N_LOGIC + SH_OE];
    end
  end
endmodule

// File: rtl/pt_and_plane_chk.sv
`timescale 1ns/1ps
module pt_and_plane_chk #(
  parameter int unsigned N_IN    = 36,
  parameter int unsigned N_LOGIC = 80,
  parameter int unsigned CFG_W   = 5978
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_ld,
  input logic               cfg_sdi,
  input logic [N_IN-1:0]    lit_in,
  input logic [N_LOGIC-1:0] logic_pt,
  input logic               shr_clk,
  input logic               shr_init,
  input logic               shr_oe,
  input logic               oe_raw,
  input logic [CFG_W-1:0]   cfg_q
);
  localparam int unsigned T0_BASE = pt_pkg::INV_BITS;
  localparam int unsigned N_LINE  = 2 * N_IN;

  // R7: everything low while loading
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |-> (logic_pt == '0 && !shr_clk && !shr_init && !shr_oe));

  // R6: serial entry at bit 0
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |=> cfg_q[0] == $past(cfg_sdi));

  // R6: the rest of the vector moves up by one
  a_r6_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |=> cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]));

  // R8: config frozen when not loading
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ld |=> $stable(cfg_q));

  // R8: with inputs and config steady, outputs steady
  a_r8_no_clocked_path: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ld && !$past(cfg_ld) && $stable(lit_in) && $stable(cfg_q))
      |-> ($stable(logic_pt) && $stable(shr_oe)));

  // R3: empty mask of term 0 gives 1
  a_r3_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ld && cfg_q[T0_BASE +: N_LINE] == '0) |-> logic_pt[0]);

  // R4: both literals of input 0 on term 0 gives 0
  a_r4_contradiction: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ld && cfg_q[T0_BASE] && cfg_q[T0_BASE+1]) |-> !logic_pt[0]);

  // R5: output enable is never inverted
  a_r5_oe_plain: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ld |-> shr_oe == oe_raw);
endmodule

bind pt_and_plane pt_and_plane_chk #(
  .N_IN    (N_IN),
  .N_LOGIC (N_LOGIC),
  .CFG_W   (CFG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_ld   (cfg_ld),
  .cfg_sdi  (cfg_sdi),
  .lit_in   (lit_in),
  .logic_pt (logic_pt),
  .shr_clk  (shr_clk),
  .shr_init (shr_init),
  .shr_oe   (shr_oe),
  .oe_raw   (pt_raw[N_PT-1]),
  .cfg_q    (cfg_q)
);

// File: tb/pt_and_plane_bench.sv
`timescale 1ns/1ps
module pt_and_plane_bench;
  localparam int NI = 36;
  localparam int NL = 72;
  localparam int NT = 83;
  localparam int NLOG = 80;
  localparam int CW = 2 + NT * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_ld = 1'b0;
  logic          cfg_sdi = 1'b0;
  logic [NI-1:0] lit_in = '0;
  logic [NLOG-1:0] logic_pt;
  logic          shr_clk, shr_init, shr_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [CW-1:0] bcfg;   // bench copy of the intended configuration

  always #2 clk = ~clk;   // 250 MHz

  pt_and_plane u_pt_and_plane (
    .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_sdi(cfg_sdi),
    .lit_in(lit_in), .logic_pt(logic_pt),
    .shr_clk(shr_clk), .shr_init(shr_init), .shr_oe(shr_oe)
  );

  // Model: walk the connected lines of term t and look for one that is low.
  function automatic logic model_term(int t, logic [NI-1:0] v);
    logic r = 1'b1;
    for (int l = 0; l < NL; l++) begin
      if (bcfg[2 + t*NL + l]) begin
        logic lv = (l % 2 == 1) ? !v[l/2] : v[l/2];
        if (lv == 1'b0) r = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check1(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [NLOG-1:0] e;
    for (int t = 0; t < NLOG; t++) e[t] = model_term(t, lit_in);
    check1(req, "logic_pt", 128'(logic_pt), 128'(e));
    check1(req, "shr_clk",  128'(shr_clk),  128'(model_term(80, lit_in) ^ bcfg[0]));
    check1(req, "shr_init", 128'(shr_init), 128'(model_term(81, lit_in) ^ bcfg[1]));
    check1(req, "shr_oe",   128'(shr_oe),   128'(model_term(82, lit_in)));
  endtask

  function automatic logic [NI-1:0] rnd_in();
    return {$urandom(), $urandom()} & {NI{1'b1}};
  endfunction

  // Drive the whole vector, top bit first, one bit per rising edge.
  task automatic load_cfg(int probe_at);
    for (int k = CW - 1; k >= 0; k--) begin
      @(negedge clk);
      cfg_ld  = 1'b1;
      cfg_sdi = bcfg[k];
      if (CW - 1 - k == probe_at) begin
        #0.5;
        check1("R7", "logic_pt during load", 128'(logic_pt), 128'(0));
        check1("R7", "shared during load",
               128'({shr_clk, shr_init, shr_oe}), 128'(0));
      end
    end
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic set_mask(int t, int l, logic b);
    bcfg[2 + t*NL + l] = b;
  endtask

  task automatic clear_term(int t);
    for (int l = 0; l < NL; l++) set_mask(t, l, 1'b0);
  endtask

  task automatic t_reset_state();
    bcfg = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      lit_in = rnd_in();
      #0.5;
      check1("R9", "logic_pt after reset", 128'(logic_pt), 128'({NLOG{1'b1}}));
      check1("R9", "shared after reset", 128'({shr_clk, shr_init, shr_oe}), 128'(3'b111));
    end
  endtask

  // Sparse random masks plus hand-placed corner terms.
  task automatic t_load_pattern_a();
    for (int k = 0; k < CW; k++) bcfg[k] = ($urandom() % 40 == 0);
    clear_term(0);                                           // empty
    clear_term(1); set_mask(1, 10, 1'b1); set_mask(1, 11, 1'b1); // input 5 both
    clear_term(2); set_mask(2, 6, 1'b1);                     // input 3 true
    clear_term(3); set_mask(3, 7, 1'b1);                     // input 3 complement
    clear_term(80);
    clear_term(81); set_mask(81, 0, 1'b1);
    clear_term(82); set_mask(82, 3, 1'b1);
    bcfg[0] = 1'b1; bcfg[1] = 1'b0;
    load_cfg(100);
  endtask

  task automatic t_random_vectors(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lit_in = rnd_in();
      #0.5;
      check_all(req);
    end
  endtask

  task automatic t_corners();
    @(negedge clk);
    lit_in = '0; #0.5;
    check1("R3", "empty term, inputs 0", 128'(logic_pt[0]), 128'(1));
    check1("R4", "contradiction, inputs 0", 128'(logic_pt[1]), 128'(0));
    check1("R1", "true literal in3=0", 128'(logic_pt[3:2]), 128'(2'b10));
    check1("R5", "inverted empty clk term", 128'(shr_clk), 128'(0));
    check_all("R1");
    lit_in = '1; #0.5;
    check1("R3", "empty term, inputs 1", 128'(logic_pt[0]), 128'(1));
    check1("R4", "contradiction, inputs 1", 128'(logic_pt[1]), 128'(0));
    check1("R1", "true literal in3=1", 128'(logic_pt[3:2]), 128'(2'b01));
    check1("R5", "oe = complement of in1", 128'(shr_oe), 128'(0));
    check_all("R4");
  endtask

  task automatic t_cfg_hold();
    @(negedge clk);
    lit_in = rnd_in();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cfg_sdi = ~cfg_sdi;
    end
    #0.5;
    check_all("R8");
  endtask

  task automatic t_comb_path();
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin
      lit_in = rnd_in();
      #0.2;
      check_all("R8");
    end
  endtask

  // Cluster c: terms built from input c, both inversions set.
  task automatic t_load_pattern_b();
    bcfg = '0;
    for (int c = 0; c < 16; c++) begin
      set_mask(5*c + 0, 2*c, 1'b1);
      set_mask(5*c + 1, 2*c + 1, 1'b1);
      set_mask(5*c + 2, 2*c, 1'b1); set_mask(5*c + 2, 2*c + 2, 1'b1);
      set_mask(5*c + 3, 2*c + 1, 1'b1); set_mask(5*c + 3, 2*c + 3, 1'b1);
    end
    set_mask(80, 40, 1'b1); set_mask(80, 41, 1'b1);
    set_mask(81, 70, 1'b1);
    set_mask(82, 71, 1'b1);
    bcfg[0] = 1'b1; bcfg[1] = 1'b1;
    load_cfg(CW - 3);
    @(negedge clk);
    lit_in = '0; #0.5;
    check1("R2", "cluster layout, inputs 0", 128'(logic_pt),
           128'({16{5'b11010}}));
    check1("R5", "inverted contradiction clk", 128'(shr_clk), 128'(1));
    check1("R5", "inverted init, in35=0", 128'(shr_init), 128'(1));
    check_all("R2");
  endtask

  initial begin
    t_reset_state();
    t_load_pattern_a();
    t_corners();
    t_random_vectors("R1", 40);
    t_cfg_hold();
    t_comb_path();
    t_load_pattern_b();
    t_random_vectors("R5", 40);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule